// File: doc/BRIEF.md
# Flash Program/Erase Status Controller

This block is the behavioural sequencer that sits behind the command port of a small flash memory model. A host issues program, block-erase, suspend, resume, clear-status and read-status commands. Each command carries a block index. The block runs every program or erase as a loop of timed pulses. After each pulse it samples a verify-pass input. It gives up once the pulse budget for that kind of operation is used up.

All outcomes go into one 8-bit status byte, which the host polls. The top bit tells the host whether the sequencer is idle. The host reads the error and suspend bits only once that bit is 1. Before the first pulse the sequencer checks the target block's lock bit and the programming-voltage-good flag. It checks the voltage flag again before each verify. A failed check aborts the operation and sets a sticky error bit. A build-time option allows operation with the programming voltage off. With that option the voltage flag is ignored and its status bit always reads 0.

Top module: `flash_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x80 and `ready_o` is 1.
- R2: Command opcodes on `cmd_op_i` are 1 program, 2 erase, 3 suspend, 4 resume, 5 clear status and 6 read status. A program or erase is accepted only while the status shows ready and nothing is suspended. Status bit 7 and `ready_o` drop on the clock edge that accepts it. A program or erase issued while busy is ignored.
- R3: A started operation spends one cycle on the lock and voltage check. It then runs pulses of `PULSE_CYCLES` cycles, each followed by one verify cycle. If verify passes on pulse n, the block is busy for exactly n*(PULSE_CYCLES+1)+1 cycles and then reports success with no new error bit.
- R4: If verify still fails after the last allowed pulse, the operation ends and sets an error bit. For an erase that is bit 5, after `MAX_ERASE_PULSES` pulses. For a program that is bit 4, after `MAX_PROG_PULSES` pulses.
- R5: A program or erase aimed at a block whose `lock_i` bit is 1 sets status bit 1 and aborts after one busy cycle.
- R6: A low `vpp_ok_i` is acted on only in the check cycle and in each verify cycle. Either case sets status bit 3 and aborts the operation. The voltage check takes precedence over the verify result.
- R7: With `ALLOW_ZERO_VPP` = 1, `vpp_ok_i` is ignored and status bit 3 always reads 0.
- R8: A suspend while busy stops the operation on the next edge. Status then reads bit 7 = 1 plus bit 6 for an erase or bit 2 for a program, and all progress is frozen. A resume restores the frozen state. The whole operation then takes exactly one busy cycle more than it would have without the suspend.
- R9: A suspend while ready, and a resume while nothing is suspended, leave the status and the timing of a running operation unchanged.
- R10: A program or erase issued while an operation is suspended is ignored.
- R11: Error bits 5, 4, 3 and 1 stay set through later operations. Only a clear-status command, which may be issued at any time, resets them.
- R12: Status bit 0 always reads 0, `ready_o` always equals status bit 7, and a read-status command changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 3 | Command opcode |
| cmd_blk_i | input | BLK_W | Target block index for program and erase |
| vpp_ok_i | input | 1 | Programming voltage is in range |
| lock_i | input | NUM_BLOCKS | Per-block lock bits |
| verify_ok_i | input | 1 | Verify of the last pulse passed |
| status_o | output | 8 | Status byte |
| ready_o | output | 1 | Idle or suspended, same as status bit 7 |

## Verification
The bench builds the controller with 3-cycle pulses, a 4-pulse erase budget, a 2-pulse program budget and 4 blocks, half of them locked. At that size it can cover every block with every pass-on-pulse count from the first pulse through exhaustion, for both operations. It can also place a voltage drop at the check and at every verify, and place a suspend or a stray command on every single busy cycle of a two-pulse run. Every expected busy length is computed from the pulse arithmetic. A second copy built with the zero-voltage option runs alongside and shares the inputs.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_PROGRAM   = 3'd1,
    OP_ERASE     = 3'd2,
    OP_SUSPEND   = 3'd3,
    OP_RESUME    = 3'd4,
    OP_CLEAR     = 3'd5,
    OP_READ_STAT = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_CHECK  = 3'd1,
    S_PULSE  = 3'd2,
    S_VERIFY = 3'd3,
    S_SUSP   = 3'd4
  } state_e;

  typedef struct packed {
    logic eerr;
    logic perr;
    logic vpp;
    logic lock;
  } err_set_t;

  localparam int unsigned NUM_STICKY = 4;
  localparam logic [7:0]  STICKY_MASK = 8'h3A;

endpackage

// File: rtl/fsc_cmd_decode.sv
module fsc_cmd_decode
  import fsc_pkg::*;
(
  input  logic       valid_i,
  input  logic [2:0] op_i,
  output logic       prog_o,
  output logic       erase_o,
  output logic       suspend_o,
  output logic       resume_o,
  output logic       clear_o
);

  op_e op;
  assign op = op_e'(op_i);

  assign prog_o    = valid_i && (op == OP_PROGRAM);
  assign erase_o   = valid_i && (op == OP_ERASE);
  assign suspend_o = valid_i && (op == OP_SUSPEND);
  assign resume_o  = valid_i && (op == OP_RESUME);
  assign clear_o   = valid_i && (op == OP_CLEAR);

endmodule

// File: rtl/fsc_pulse_timer.sv
module fsc_pulse_timer #(
  parameter int unsigned PULSE_CYCLES     = 16,
  parameter int unsigned MAX_ERASE_PULSES = 8,
  parameter int unsigned MAX_PROG_PULSES  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic next_i,
  input  logic tick_i,
  input  logic is_erase_i,
  output logic pulse_end_o,
  output logic last_pulse_o
);

  localparam int unsigned MAX_PULSES =
    (MAX_ERASE_PULSES > MAX_PROG_PULSES) ? MAX_ERASE_PULSES : MAX_PROG_PULSES;
  localparam int unsigned NUM_W = $clog2(MAX_PULSES + 1);

  logic [NUM_W-1:0] num_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     num_q <= '0;
    else if (load_i) num_q <= NUM_W'(1);
    else if (next_i) num_q <= num_q + NUM_W'(1);
  end

  assign last_pulse_o = is_erase_i ? (num_q == NUM_W'(MAX_ERASE_PULSES))
                                   : (num_q == NUM_W'(MAX_PROG_PULSES));

  generate
    if (PULSE_CYCLES <= 1) begin : g_single
      assign pulse_end_o = 1'b1;
    end else begin : g_count
      localparam int unsigned CNT_W = $clog2(PULSE_CYCLES);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                cnt_q <= '0;
        else if (load_i || next_i)  cnt_q <= '0;
        else if (tick_i)            cnt_q <= pulse_end_o ? '0 : cnt_q + CNT_W'(1);
      end

      assign pulse_end_o = (cnt_q == CNT_W'(PULSE_CYCLES - 1));
    end
  endgenerate

endmodule

// File: rtl/fsc_seq_fsm.sv
module fsc_seq_fsm
  import fsc_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS     = 4,
  parameter int unsigned BLK_W          = 2,
  parameter bit          ALLOW_ZERO_VPP = 1'b0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  prog_i,
  input  logic                  erase_i,
  input  logic                  suspend_i,
  input  logic                  resume_i,
  input  logic [BLK_W-1:0]      blk_i,
  input  logic [NUM_BLOCKS-1:0] lock_i,
  input  logic                  vpp_ok_i,
  input  logic                  verify_ok_i,
  input  logic                  pulse_end_i,
  input  logic                  last_pulse_i,
  output logic                  t_load_o,
  output logic                  t_next_o,
  output logic                  t_tick_o,
  output logic                  is_erase_o,
  output logic                  busy_o,
  output logic                  susp_erase_o,
  output logic                  susp_prog_o,
  output err_set_t              err_set_o
);

  state_e           state_q, state_d, ret_q, ret_d;
  logic             erase_q, erase_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic             vpp_bad;

  assign vpp_bad = !ALLOW_ZERO_VPP && !vpp_ok_i;

  always_comb begin
    state_d   = state_q;
    ret_d     = ret_q;
    erase_d   = erase_q;
    blk_d     = blk_q;
    err_set_o = '0;
    t_load_o  = 1'b0;
    t_next_o  = 1'b0;
    t_tick_o  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (prog_i || erase_i) begin
          state_d = S_CHECK;
          erase_d = erase_i;
          blk_d   = blk_i;
        end
      end
      S_CHECK, S_PULSE, S_VERIFY: begin
        if (suspend_i) begin
          // freeze everything; timer holds because no control strobe fires
          ret_d   = state_q;
          state_d = S_SUSP;
        end else if (state_q == S_CHECK) begin
          if (lock_i[blk_q]) begin
            err_set_o.lock = 1'b1;
            state_d        = S_IDLE;
          end else if (vpp_bad) begin
            err_set_o.vpp = 1'b1;
            state_d       = S_IDLE;
          end else begin
            t_load_o = 1'b1;
            state_d  = S_PULSE;
          end
        end else if (state_q == S_PULSE) begin
          t_tick_o = 1'b1;
          if (pulse_end_i) state_d = S_VERIFY;
        end else begin
          if (vpp_bad) begin
            err_set_o.vpp = 1'b1;
            state_d       = S_IDLE;
          end else if (verify_ok_i) begin
            state_d = S_IDLE;
          end else if (last_pulse_i) begin
            err_set_o.eerr = erase_q;
            err_set_o.perr = !erase_q;
            state_d        = S_IDLE;
          end else begin
            t_next_o = 1'b1;
            state_d  = S_PULSE;
          end
        end
      end
      S_SUSP: begin
        if (resume_i) state_d = ret_q;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ret_q   <= S_IDLE;
      erase_q <= 1'b0;
      blk_q   <= '0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      erase_q <= erase_d;
      blk_q   <= blk_d;
    end
  end

  assign is_erase_o   = erase_q;
  assign busy_o       = (state_q == S_CHECK) || (state_q == S_PULSE) || (state_q == S_VERIFY);
  assign susp_erase_o = (state_q == S_SUSP) && erase_q;
  assign susp_prog_o  = (state_q == S_SUSP) && !erase_q;

endmodule

// File: rtl/fsc_status_reg.sv
module fsc_status_reg
  import fsc_pkg::*;
#(
  parameter bit ALLOW_ZERO_VPP = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  err_set_t   set_i,
  input  logic       clear_i,
  input  logic       busy_i,
  input  logic       susp_erase_i,
  input  logic       susp_prog_i,
  output logic [7:0] status_o
);

  logic [NUM_STICKY-1:0] set_vec, sticky_q;
  logic                  vpp_bit;

  assign set_vec = {set_i.eerr, set_i.perr, set_i.vpp, set_i.lock};

  generate
    for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
      // a same-cycle set wins over clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         sticky_q[i] <= 1'b0;
        else if (set_vec[i]) sticky_q[i] <= 1'b1;
        else if (clear_i)    sticky_q[i] <= 1'b0;
      end
    end
  endgenerate

  assign vpp_bit = sticky_q[1] && !ALLOW_ZERO_VPP;

  assign status_o = {!busy_i, susp_erase_i, sticky_q[3], sticky_q[2],
                     vpp_bit, susp_prog_i, sticky_q[0], 1'b0};

endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import fsc_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS       = 4,
  parameter int unsigned BLK_W            = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  parameter int unsigned PULSE_CYCLES     = 16,
  parameter int unsigned MAX_ERASE_PULSES = 8,
  parameter int unsigned MAX_PROG_PULSES  = 4,
  parameter bit          ALLOW_ZERO_VPP   = 1'b0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  input  logic [2:0]            cmd_op_i,
  input  logic [BLK_W-1:0]      cmd_blk_i,
  input  logic                  vpp_ok_i,
  input  logic [NUM_BLOCKS-1:0] lock_i,
  input  logic                  verify_ok_i,
  output logic [7:0]            status_o,
  output logic                  ready_o
);

  logic     prog, erase, suspend, resume, clear;
  logic     t_load, t_next, t_tick, is_erase, pulse_end, last_pulse;
  logic     busy, susp_erase, susp_prog;
  err_set_t err_set;

  fsc_cmd_decode u_dec (
    .valid_i   (cmd_valid_i),
    .op_i      (cmd_op_i),
    .prog_o    (prog),
    .erase_o   (erase),
    .suspend_o (suspend),
    .resume_o  (resume),
    .clear_o   (clear)
  );

  fsc_seq_fsm #(
    .NUM_BLOCKS     (NUM_BLOCKS),
    .BLK_W          (BLK_W),
    .ALLOW_ZERO_VPP (ALLOW_ZERO_VPP)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .prog_i       (prog),
    .erase_i      (erase),
    .suspend_i    (suspend),
    .resume_i     (resume),
    .blk_i        (cmd_blk_i),
    .lock_i       (lock_i),
    .vpp_ok_i     (vpp_ok_i),
    .verify_ok_i  (verify_ok_i),
    .pulse_end_i  (pulse_end),
    .last_pulse_i (last_pulse),
    .t_load_o     (t_load),
    .t_next_o     (t_next),
    .t_tick_o     (t_tick),
    .is_erase_o   (is_erase),
    .busy_o       (busy),
    .susp_erase_o (susp_erase),
    .susp_prog_o  (susp_prog),
    .err_set_o    (err_set)
  );

  fsc_pulse_timer #(
    .PULSE_CYCLES     (PULSE_CYCLES),
    .MAX_ERASE_PULSES (MAX_ERASE_PULSES),
    .MAX_PROG_PULSES  (MAX_PROG_PULSES)
  ) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (t_load),
    .next_i       (t_next),
    .tick_i       (t_tick),
    .is_erase_i   (is_erase),
    .pulse_end_o  (pulse_end),
    .last_pulse_o (last_pulse)
  );

  fsc_status_reg #(
    .ALLOW_ZERO_VPP (ALLOW_ZERO_VPP)
  ) u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (err_set),
    .clear_i      (clear),
    .busy_i       (busy),
    .susp_erase_i (susp_erase),
    .susp_prog_i  (susp_prog),
    .status_o     (status_o)
  );

  assign ready_o = !busy;

endmodule

// File: rtl/fsc_checker.sv
module fsc_checker
  import fsc_pkg::*;
#(
  parameter bit ALLOW_ZERO_VPP = 1'b0
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic [2:0] cmd_op_i,
  input logic [7:0] status_o,
  input logic       ready_o
);

  logic c_clr, c_susp, c_res, c_start, idle_free;
  assign c_clr     = cmd_valid_i && (cmd_op_i == OP_CLEAR);
  assign c_susp    = cmd_valid_i && (cmd_op_i == OP_SUSPEND);
  assign c_res     = cmd_valid_i && (cmd_op_i == OP_RESUME);
  assign c_start   = cmd_valid_i && ((cmd_op_i == OP_PROGRAM) || (cmd_op_i == OP_ERASE));
  assign idle_free = status_o[7] && !status_o[6] && !status_o[2];

  p_rsvd_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] == 1'b0);

  p_accept_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_start && idle_free |=> !ready_o && !status_o[7]);

  p_susp_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[6] || status_o[2]) |-> status_o[7]);

  p_susp_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[6] && status_o[2]));

  p_susp_take_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_susp && !status_o[7] |=> status_o[7] && $onehot0({status_o[6], status_o[2]})
                               && (status_o[6] || status_o[2]));

  p_idle_susp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_susp && idle_free |=> $stable(status_o));

  p_idle_resume_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_res && idle_free |=> $stable(status_o));

  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_clr |=> ((status_o & STICKY_MASK) & $past(status_o & STICKY_MASK))
               == $past(status_o & STICKY_MASK));

  generate
    if (ALLOW_ZERO_VPP) begin : g_zv
      p_zero_vpp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !status_o[3]);
    end
  endgenerate

endmodule

bind flash_status_ctrl fsc_checker #(
  .ALLOW_ZERO_VPP (ALLOW_ZERO_VPP)
) u_fsc_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .status_o    (status_o),
  .ready_o     (ready_o)
);

// File: tb/flash_status_ctrl_test.sv
`timescale 1ns/1ps
module flash_status_ctrl_test;

  localparam int P  = 3;
  localparam int ME = 4;
  localparam int MP = 2;
  localparam int NB = 4;
  localparam logic [2:0] C_PROG = 3'd1, C_ERASE = 3'd2, C_SUSP = 3'd3,
                         C_RES = 3'd4, C_CLR = 3'd5, C_RD = 3'd6;
  localparam logic [NB-1:0] LOCKS = 4'b0101;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [1:0]    cmd_blk = '0;
  logic          vpp_ok = 1'b1;
  logic [NB-1:0] lock = LOCKS;
  logic          verify_ok = 1'b0;
  logic [7:0]    st, st_zv;
  logic          rdy, rdy_zv;

  int vecs = 0;
  int errs = 0;

  always #10 clk = ~clk;

  flash_status_ctrl #(.NUM_BLOCKS(NB), .PULSE_CYCLES(P), .MAX_ERASE_PULSES(ME),
                      .MAX_PROG_PULSES(MP), .ALLOW_ZERO_VPP(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_blk_i(cmd_blk), .vpp_ok_i(vpp_ok), .lock_i(lock), .verify_ok_i(verify_ok),
    .status_o(st), .ready_o(rdy));

  flash_status_ctrl #(.NUM_BLOCKS(NB), .PULSE_CYCLES(P), .MAX_ERASE_PULSES(ME),
                      .MAX_PROG_PULSES(MP), .ALLOW_ZERO_VPP(1'b1)) uut_zv (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_blk_i(cmd_blk), .vpp_ok_i(vpp_ok), .lock_i(lock), .verify_ok_i(verify_ok),
    .status_o(st_zv), .ready_o(rdy_zv));

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one-cycle command issued at a negedge; returns at the next negedge
  task automatic issue(input logic [2:0] op, input int blk);
    cmd_valid = 1'b1; cmd_op = op; cmd_blk = 2'(blk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic clear_all();
    issue(C_CLR, 0);
    chk("R11 clear-status empties errors", int'(st), 'h80);
  endtask

  // npass: pass on that pulse (0 = never); vpp_m: -1 none, 0 check, m>0 verify m
  // susp_k: suspend at busy cycle; inj_k/inj_op: stray command at busy cycle
  task automatic run_op(input logic [2:0] op, input int blk, input int npass,
                        input int vpp_m, input int susp_k, input int inj_k,
                        input logic [2:0] inj_op, output int busy, output int fin);
    int c, p, shift;
    logic [7:0] susp_exp;
    c = 0; shift = 0;
    cmd_valid = 1'b1; cmd_op = op; cmd_blk = 2'(blk);
    forever begin
      @(negedge clk);
      cmd_valid = 1'b0; vpp_ok = 1'b1;
      if (rdy || c > 500) break;
      p = c - shift;
      verify_ok = (npass > 0) && (p >= (npass - 1) * (P + 1) + 1);
      if (vpp_m == 0 && p == 0) vpp_ok = 1'b0;
      if (vpp_m > 0 && p == vpp_m * (P + 1)) vpp_ok = 1'b0;
      if (c == inj_k) begin cmd_valid = 1'b1; cmd_op = inj_op; cmd_blk = 2'(blk); end
      if (c == susp_k) begin
        vpp_ok = 1'b1;
        susp_exp = (op == C_ERASE) ? 8'hC0 : 8'h84;
        issue(C_SUSP, blk);
        chk("R8 suspended status", int'(st), int'(susp_exp));
        issue(C_PROG, blk);
        chk("R10 program while suspended ignored", int'(st), int'(susp_exp));
        issue(C_ERASE, blk);
        chk("R10 erase while suspended ignored", int'(st), int'(susp_exp));
        cmd_valid = 1'b1; cmd_op = C_RES;
        shift = 1;
      end
      c++;
    end
    verify_ok = 1'b0;
    busy = c;
    fin  = int'(st);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin : main
    int busy, fin, mx, exp_busy, exp_st, zb;
    logic [2:0] op;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", int'(st), 'h80);
    chk("R1 reset ready", int'(rdy), 1);
    chk("R1 reset status zero-vpp build", int'(st_zv), 'h80);

    // R7: voltage off, zero-voltage build runs, normal build aborts at check
    vpp_ok = 1'b0; verify_ok = 1'b1;
    cmd_valid = 1'b1; cmd_op = C_ERASE; cmd_blk = 2'd1;
    zb = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      if (!rdy_zv) zb++;
      chk("R7 bit3 stays 0 with zero-voltage option", int'(st_zv[3]), 0);
    end
    chk("R7 zero-voltage build busy length", zb, P + 2);
    chk("R7 zero-voltage build final status", int'(st_zv), 'h80);
    chk("R6 normal build aborts on low voltage", int'(st), 'h88);
    vpp_ok = 1'b1; verify_ok = 1'b0;
    clear_all();

    // R2/R3/R4/R5 sweep over ops, blocks and pass pulse
    for (int o = 0; o < 2; o++) begin
      op = o ? C_ERASE : C_PROG;
      mx = o ? ME : MP;
      for (int b = 0; b < NB; b++) begin
        for (int n = 0; n <= mx; n++) begin
          run_op(op, b, n, -1, -1, -1, C_RD, busy, fin);
          if (LOCKS[b]) begin
            chk("R5 locked block busy length", busy, 1);
            chk("R5 locked block status", fin, 'h82);
          end else if (n == 0) begin
            chk("R4 exhausted busy length", busy, mx * (P + 1) + 1);
            chk("R4 exhausted error bit", fin, o ? 'hA0 : 'h90);
          end else begin
            chk("R3 pass busy length", busy, n * (P + 1) + 1);
            chk("R3 pass status", fin, 'h80);
          end
          if (fin != 'h80) clear_all();
        end
      end
    end

    // R6 voltage drop at check and at each verify
    for (int o = 0; o < 2; o++) begin
      op = o ? C_ERASE : C_PROG;
      mx = o ? ME : MP;
      for (int m = 0; m <= mx; m++) begin
        run_op(op, 1, 0, m, -1, -1, C_RD, busy, fin);
        exp_busy = (m == 0) ? 1 : m * (P + 1) + 1;
        chk("R6 low-voltage abort busy length", busy, exp_busy);
        chk("R6 low-voltage abort status", fin, 'h88);
        clear_all();
      end
    end

    // R11 sticky across later operations
    run_op(C_ERASE, 0, 1, -1, -1, -1, C_RD, busy, fin);
    chk("R11 lock error set", fin, 'h82);
    run_op(C_PROG, 1, 1, -1, -1, -1, C_RD, busy, fin);
    chk("R11 lock error survives success", fin, 'h82);
    run_op(C_PROG, 3, 0, 1, -1, -1, C_RD, busy, fin);
    chk("R11 errors accumulate", fin, 'h8A);

    // R9/R12 ignored commands while ready, errors present
    issue(C_SUSP, 1);
    chk("R9 suspend while ready ignored", int'(st), 'h8A);
    issue(C_RES, 1);
    chk("R9 resume while not suspended ignored", int'(st), 'h8A);
    issue(C_RD, 1);
    chk("R12 read-status changes nothing", int'(st), 'h8A);
    chk("R12 ready_o equals bit 7", int'(rdy), int'(st[7]));
    clear_all();

    // R8 suspend at every busy cycle, R9/R2 stray commands at every busy cycle
    for (int o = 0; o < 2; o++) begin
      op = o ? C_ERASE : C_PROG;
      for (int k = 0; k <= 2 * (P + 1); k++) begin
        run_op(op, 1, 2, -1, k, -1, C_RD, busy, fin);
        chk("R8 suspend adds one busy cycle", busy, 2 * (P + 1) + 2);
        chk("R8 resumed op completes", fin, 'h80);
        run_op(op, 1, 2, -1, -1, k, C_RES, busy, fin);
        chk("R9 resume while busy ignored", busy, 2 * (P + 1) + 1);
        run_op(op, 1, 2, -1, -1, k, o ? C_PROG : C_ERASE, busy, fin);
        chk("R2 start while busy ignored", busy, 2 * (P + 1) + 1);
        chk("R2 start while busy status", fin, 'h80);
      end
    end

    exp_st = 'h80;
    chk("R12 final status", int'(st), exp_st);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule